// File: doc/BRIEF.md
# Boot Strobe and Chip-Select Steering Unit

This unit sits between the external memory controller and the device pins. While reset is held it samples a four-bit boot-source code from four general-purpose input pins. When reset is released it freezes that code and decodes it into one of five boot sources. If the code selects NAND boot, an override flag comes up set. While the flag is set, the chip-select-1 region is steered to the internal boot ROM and the external chip-select-1 pin is kept inactive. Software can clear or set the flag through a one-bit register port.

The NAND read and write strobes are the memory controller's active-low output-enable and write-enable. Each is passed through only when one qualifying high address bit is 1. That bit depends on the bus width: logical A23 for 8-bit, A24 for 16-bit and A25 for 32-bit. The unit also shifts logical address bits onto the physical address pins by width, so the qualifying bit always lands on the top pin. Other external devices can therefore be accessed with the NAND chip select held low, provided they live where the qualifying bit is 0.

Top module: `nand_boot_ctrl`

## Requirements
- R1: While `rst_n` is low the boot-mode register takes `boot_pins_i` on every rising clock edge. From the first edge with `rst_n` high it keeps the value captured at the last low edge, whatever the pins do afterwards, and shows it on `boot_mode_o`.
- R2: `boot_src_o` decodes the held mode using the default parameter codes: 4'h0 gives 0 (NOR), 4'h1 gives 1 (NAND), 4'h2 gives 2 (SRAM), 4'h3 gives 3 (I2C) and 4'h4 gives 4 (UART). Every other code gives 7 (none). `nand_boot_o` is 1 only for the NAND code.
- R3: After reset the override flag on `reg_rbit_o` is 1 if the captured code is the NAND code, and 0 otherwise.
- R4: While the override flag is 1, `cs1_pin_n_o` is 1 and `bootrom_sel_o` equals the inverse of `mc_cs1_n_i`.
- R5: While the override flag is 0, `cs1_pin_n_o` equals `mc_cs1_n_i` and `bootrom_sel_o` is 0.
- R6: A clock edge with `reg_we_i` high loads `reg_wbit_i` into the override flag, and the new value is visible after that edge. With `reg_we_i` low, `reg_wbit_i` has no effect.
- R7: `nand_re_n_o` is 0 exactly when `mc_oe_n_i` is 0 and the qualifying address bit is 1. In every other case it is 1.
- R8: `nand_we_n_o` is 0 exactly when `mc_we_n_i` is 0 and the qualifying address bit is 1. In every other case it is 1.
- R9: `bus_width_i` encodes the bus width as 00 = 8-bit, 01 = 16-bit, 10 = 32-bit, and treats 11 as 8-bit. The qualifying bit is `laddr_i[23]`, `laddr_i[24]` and `laddr_i[25]` respectively.
- R10: `pin_addr_o[n]` carries `laddr_i[n]` for 8-bit, `laddr_i[n+1]` for 16-bit and `laddr_i[n+2]` for 32-bit, for n from 0 to 23.
- R11: The strobes, the pin address, `cs1_pin_n_o` and `bootrom_sel_o` follow their inputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the boot code is sampled while it is low |
| boot_pins_i | input | 4 | Boot-source code pins |
| bus_width_i | input | 2 | Memory bus width select |
| laddr_i | input | 26 | Logical address from the memory controller |
| mc_oe_n_i | input | 1 | Controller output enable, active low |
| mc_we_n_i | input | 1 | Controller write enable, active low |
| mc_cs1_n_i | input | 1 | Controller chip select 1, active low |
| reg_we_i | input | 1 | Override register write strobe |
| reg_wbit_i | input | 1 | Override register write data |
| pin_addr_o | output | 24 | Physical address pins |
| nand_re_n_o | output | 1 | NAND read enable, active low |
| nand_we_n_o | output | 1 | NAND write enable, active low |
| cs1_pin_n_o | output | 1 | External chip select 1 pin, active low |
| bootrom_sel_o | output | 1 | Internal boot ROM select |
| reg_rbit_o | output | 1 | Override register read data |
| boot_mode_o | output | 4 | Held boot-mode code |
| boot_src_o | output | 3 | Decoded boot source |
| nand_boot_o | output | 1 | Held code selects NAND boot |

## Verification
If the wrong boot code is latched, `boot_mode_o` and `boot_src_o` are wrong from the first cycle after reset release, and they stay wrong until the next reset. A bad override flag shows on `reg_rbit_o` at once. It shows on the chip-select and boot-ROM outputs as soon as the controller next drives chip select 1. A wrong width decode or a wrong qualifier is combinational, so it shows on the strobes and pins in the same cycle as the stimulus. Driving the two unselected high address bits opposite to the selected one makes any wrong bit choice visible.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

    typedef enum logic [1:0] {
        BW_8   = 2'b00,
        BW_16  = 2'b01,
        BW_32  = 2'b10,
        BW_RSV = 2'b11
    } bus_width_e;

    typedef enum logic [2:0] {
        SRC_NOR  = 3'd0,
        SRC_NAND = 3'd1,
        SRC_SRAM = 3'd2,
        SRC_I2C  = 3'd3,
        SRC_UART = 3'd4,
        SRC_NONE = 3'd7
    } boot_src_e;

    // Logical-to-pin shift for a width code; the reserved code acts as 8-bit.
    function automatic logic [1:0] width_shift(input logic [1:0] w);
        case (bus_width_e'(w))
            BW_16:   return 2'd1;
            BW_32:   return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/boot_state_regs.sv
module boot_state_regs
    import nbc_pkg::*;
#(
    parameter int unsigned       MODE_W    = 4,
    parameter logic [MODE_W-1:0] CODE_NOR  = MODE_W'(0),
    parameter logic [MODE_W-1:0] CODE_NAND = MODE_W'(1),
    parameter logic [MODE_W-1:0] CODE_SRAM = MODE_W'(2),
    parameter logic [MODE_W-1:0] CODE_I2C  = MODE_W'(3),
    parameter logic [MODE_W-1:0] CODE_UART = MODE_W'(4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] boot_pins_i,
    input  logic              reg_we_i,
    input  logic              reg_wbit_i,
    output logic [MODE_W-1:0] mode_o,
    output logic [2:0]        src_o,
    output logic              nand_boot_o,
    output logic              ovr_o
);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              ovr;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (!rst_n) begin
            state_d.mode = boot_pins_i;
            state_d.ovr  = (boot_pins_i == CODE_NAND);
        end else if (reg_we_i) begin
            state_d.ovr = reg_wbit_i;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    boot_src_e src;
    always_comb begin
        if (state_q.mode == CODE_NOR)       src = SRC_NOR;
        else if (state_q.mode == CODE_NAND) src = SRC_NAND;
        else if (state_q.mode == CODE_SRAM) src = SRC_SRAM;
        else if (state_q.mode == CODE_I2C)  src = SRC_I2C;
        else if (state_q.mode == CODE_UART) src = SRC_UART;
        else                                src = SRC_NONE;
    end

    assign mode_o      = state_q.mode;
    assign src_o       = src;
    assign nand_boot_o = (src == SRC_NAND);
    assign ovr_o       = state_q.ovr;

    // Marks cycles whose previous edge was already out of reset.
    logic run_d, run_q;
    always_comb run_d = rst_n;
    always_ff @(posedge clk) begin
        run_q <= run_d;
    end

    // R1: mode frozen once out of reset
    assert_mode_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> $stable(state_q.mode));

    // R6: a write lands on the following cycle
    assert_ovr_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_i |=> (ovr_o == $past(reg_wbit_i)));

    // R6: no write, no change
    assert_ovr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !$past(reg_we_i)) |-> $stable(state_q.ovr));

endmodule

// File: rtl/addr_pin_mapper.sv
module addr_pin_mapper
    import nbc_pkg::*;
#(
    parameter int unsigned PIN_W   = 24,
    localparam int unsigned LADDR_W = PIN_W + 2
) (
    input  logic [LADDR_W-1:0] laddr_i,
    input  logic [1:0]         width_i,
    output logic [PIN_W-1:0]   pin_o,
    output logic               qual_o
);

    logic [1:0] shift;
    assign shift = width_shift(width_i);

    for (genvar g = 0; g < PIN_W; g++) begin : g_pin
        assign pin_o[g] = (shift == 2'd2) ? laddr_i[g+2] :
                          (shift == 2'd1) ? laddr_i[g+1] :
                                            laddr_i[g];
    end

    // The qualifying bit always lands on the topmost pin.
    assign qual_o = pin_o[PIN_W-1];

endmodule

// File: rtl/nand_strobe_gate.sv
module nand_strobe_gate (
    input  logic oe_n_i,
    input  logic we_n_i,
    input  logic qual_i,
    output logic re_n_o,
    output logic wr_n_o
);

    assign re_n_o = ~(~oe_n_i & qual_i);
    assign wr_n_o = ~(~we_n_i & qual_i);

endmodule

// File: rtl/nand_boot_ctrl.sv
module nand_boot_ctrl
    import nbc_pkg::*;
#(
    parameter int unsigned PIN_W  = 24,
    parameter int unsigned MODE_W = 4,
    localparam int unsigned LADDR_W = PIN_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MODE_W-1:0]  boot_pins_i,
    input  logic [1:0]         bus_width_i,
    input  logic [LADDR_W-1:0] laddr_i,
    input  logic               mc_oe_n_i,
    input  logic               mc_we_n_i,
    input  logic               mc_cs1_n_i,
    input  logic               reg_we_i,
    input  logic               reg_wbit_i,
    output logic [PIN_W-1:0]   pin_addr_o,
    output logic               nand_re_n_o,
    output logic               nand_we_n_o,
    output logic               cs1_pin_n_o,
    output logic               bootrom_sel_o,
    output logic               reg_rbit_o,
    output logic [MODE_W-1:0]  boot_mode_o,
    output logic [2:0]         boot_src_o,
    output logic               nand_boot_o
);

    logic ovr;
    logic qual;

    boot_state_regs #(.MODE_W(MODE_W)) i_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .boot_pins_i (boot_pins_i),
        .reg_we_i    (reg_we_i),
        .reg_wbit_i  (reg_wbit_i),
        .mode_o      (boot_mode_o),
        .src_o       (boot_src_o),
        .nand_boot_o (nand_boot_o),
        .ovr_o       (ovr)
    );

    addr_pin_mapper #(.PIN_W(PIN_W)) i_map (
        .laddr_i (laddr_i),
        .width_i (bus_width_i),
        .pin_o   (pin_addr_o),
        .qual_o  (qual)
    );

    nand_strobe_gate i_gate (
        .oe_n_i (mc_oe_n_i),
        .we_n_i (mc_we_n_i),
        .qual_i (qual),
        .re_n_o (nand_re_n_o),
        .wr_n_o (nand_we_n_o)
    );

    // Chip-select steering.
    assign cs1_pin_n_o   = ovr | mc_cs1_n_i;
    assign bootrom_sel_o = ovr & ~mc_cs1_n_i;
    assign reg_rbit_o    = ovr;

    // Qualifier taken straight from the width code, apart from the mapper.
    logic chk_qual;
    assign chk_qual = (bus_width_i == 2'b01) ? laddr_i[PIN_W]   :
                      (bus_width_i == 2'b10) ? laddr_i[PIN_W+1] :
                                               laddr_i[PIN_W-1];

    // R4: override keeps the external pin inactive
    assert_cs1_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rbit_o |-> (cs1_pin_n_o && (bootrom_sel_o == !mc_cs1_n_i)));

    // R5: no override, pin passes through
    assert_cs1_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rbit_o |-> ((cs1_pin_n_o == mc_cs1_n_i) && !bootrom_sel_o));

    // R7: read strobe needs the controller output enable
    assert_re_needs_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n_o |-> !mc_oe_n_i);

    // R8: write strobe needs the controller write enable
    assert_we_needs_we_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n_o |-> !mc_we_n_i);

    // R9: qualifier low keeps both strobes idle
    assert_qual_low_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_qual |-> (nand_re_n_o && nand_we_n_o));

endmodule

// File: tb/test_nand_boot_ctrl.sv
module test_nand_boot_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  boot_pins;
    logic [1:0]  bus_width;
    logic [25:0] laddr;
    logic        oe_n, we_n, cs1_n, reg_we, reg_wbit;
    logic [23:0] pin_addr;
    logic        re_n_o, we_n_o, cs1_pin_n, rom_sel, rbit, nand_boot;
    logic [3:0]  mode;
    logic [2:0]  src;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    nand_boot_ctrl i_nand_boot_ctrl (
        .clk(clk), .rst_n(rst_n), .boot_pins_i(boot_pins), .bus_width_i(bus_width),
        .laddr_i(laddr), .mc_oe_n_i(oe_n), .mc_we_n_i(we_n), .mc_cs1_n_i(cs1_n),
        .reg_we_i(reg_we), .reg_wbit_i(reg_wbit), .pin_addr_o(pin_addr),
        .nand_re_n_o(re_n_o), .nand_we_n_o(we_n_o), .cs1_pin_n_o(cs1_pin_n),
        .bootrom_sel_o(rom_sel), .reg_rbit_o(rbit), .boot_mode_o(mode),
        .boot_src_o(src), .nand_boot_o(nand_boot)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_shift(input logic [1:0] w);
        return (w == 2'b01) ? 1 : (w == 2'b10) ? 2 : 0;
    endfunction

    function automatic logic [2:0] exp_src(input logic [3:0] c);
        return (c <= 4'h4) ? c[2:0] : 3'd7;
    endfunction

    task automatic apply_reset(input logic [3:0] code);
        @(negedge clk);
        rst_n = 1'b0; boot_pins = code;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        boot_pins = ~code;
    endtask

    task automatic write_ovr(input logic v);
        @(negedge clk);
        reg_we = 1'b1; reg_wbit = v;
        @(negedge clk);
        reg_we = 1'b0; reg_wbit = ~v;
        #1;
    endtask

    // R1 R2 R3: code capture, decode and override reset value
    task automatic t_boot_modes();
        logic [3:0] codes [6] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'hA};
        foreach (codes[i]) begin
            apply_reset(codes[i]);
            repeat (3) @(negedge clk);
            #1;
            check("R1 held mode", mode, codes[i]);
            check("R2 source", src, exp_src(codes[i]));
            check("R2 nand flag", nand_boot, codes[i] == 4'h1);
            check("R3 override reset", rbit, codes[i] == 4'h1);
        end
    endtask

    // R4 R5 R6: chip-select steering and the override register
    task automatic t_override();
        apply_reset(4'h1);
        cs1_n = 1'b0; #1;
        check("R4 cs1 blocked", cs1_pin_n, 1'b1);
        check("R4 rom sel", rom_sel, 1'b1);
        cs1_n = 1'b1; #1;
        check("R4 rom idle", rom_sel, 1'b0);
        @(negedge clk);
        reg_we = 1'b0; reg_wbit = 1'b0;
        @(negedge clk); #1;
        check("R6 no write", rbit, 1'b1);
        write_ovr(1'b0);
        check("R6 cleared", rbit, 1'b0);
        cs1_n = 1'b0; #1;
        check("R5 cs1 passes", cs1_pin_n, 1'b0);
        check("R5 rom off", rom_sel, 1'b0);
        cs1_n = 1'b1; #1;
        check("R5 cs1 high", cs1_pin_n, 1'b1);
        write_ovr(1'b1);
        check("R6 set", rbit, 1'b1);
        cs1_n = 1'b0; #1;
        check("R4 re-blocked", cs1_pin_n, 1'b1);
        cs1_n = 1'b1;
        apply_reset(4'h2);
        cs1_n = 1'b0; #1;
        check("R3 non-nand reset", rbit, 1'b0);
        check("R5 non-nand pass", cs1_pin_n, 1'b0);
        cs1_n = 1'b1;
    endtask

    // R7 R8 R9 R11: strobe gating per width, unselected high bits opposite
    task automatic t_strobes();
        for (int w = 0; w < 4; w++) begin
            for (int q = 0; q < 2; q++) begin
                for (int s = 0; s < 4; s++) begin
                    @(negedge clk);
                    bus_width = 2'(w);
                    laddr = 26'h0123456;
                    laddr[25:23] = q[0] ? 3'b000 : 3'b111;
                    laddr[23 + exp_shift(2'(w))] = q[0];
                    oe_n = s[0]; we_n = s[1];
                    #1;
                    check("R7 R9 R11 read strobe", re_n_o, !(!s[0] && q[0]));
                    check("R8 R9 R11 write strobe", we_n_o, !(!s[1] && q[0]));
                end
            end
        end
        oe_n = 1'b1; we_n = 1'b1;
    endtask

    // R10 R11: address pin mapping, walking ones and patterns
    task automatic t_pinmap();
        for (int w = 0; w < 4; w++) begin
            for (int k = 0; k < 28; k++) begin
                @(negedge clk);
                bus_width = 2'(w);
                laddr = (k < 26) ? (26'd1 << k) : ((k == 26) ? 26'h2AAAAAA : 26'h1555555);
                #1;
                check("R10 R11 pin map", pin_addr, 24'(laddr >> exp_shift(2'(w))));
            end
        end
    endtask

    initial begin
        rst_n = 1'b0; boot_pins = 4'h0; bus_width = 2'b00; laddr = '0;
        oe_n = 1'b1; we_n = 1'b1; cs1_n = 1'b1; reg_we = 1'b0; reg_wbit = 1'b0;
        t_boot_modes();
        t_override();
        t_strobes();
        t_pinmap();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule